// File: doc/BRIEF.md
# In-band transmit command interpreter

This block sits between a byte stream headed for an asynchronous serial transmitter and the transmitter itself. When interpretation is switched on, the block watches the stream for an escape byte. It treats the byte after the escape as a command, and that command can force the line into a break, release a break, or stall the stream for a programmed number of bit-time ticks. Every other byte reaches the transmitter unchanged and in the order it arrived.

Bytes enter through a valid/ready handshake and leave through a one-entry output register with its own valid/ready handshake. The bit-time tick is a single-cycle strobe from the baud generator, and the block uses it only to time pauses. The line-break output is a level that tells the shifter to drive the space level for as long as it is high.

Top module: `esc_cmd_tx`

## Requirements
- R1: While `cmd_en` is low, every input byte, including 0x00 and 0x82, comes out on `out_data` unchanged and in order.
- R2: While `cmd_en` is high, any byte other than 0x00 comes out unchanged. `out_valid` rises in the cycle after the input handshake, and the escape byte 0x00 produces no output on its own.
- R3: The pair 0x00 0x00 produces exactly one 0x00 output byte.
- R4: The pair 0x00 0x81 sets `brk_force` high from the cycle after the code is accepted. While `brk_force` is high, a data byte is not accepted (`in_ready` low) and nothing is output.
- R5: The pair 0x00 0x83 clears `brk_force`. A data byte that was held back is then accepted and output.
- R6: The sequence 0x00 0x82 N holds `in_ready` low after N is accepted until N ticks have been seen. N = 0 causes no pause.
- R7: After 0x00, any code byte other than 0x00, 0x81, 0x82 or 0x83 is dropped and raises `cmd_err` for exactly one cycle. A literal 0x00 0x00 pair arriving during a break is also dropped and raises the same pulse.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and the next data byte is refused.
- R9: After reset, `out_valid`, `brk_force` and `cmd_err` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Enables interpretation of in-band commands |
| tick | input | 1 | One-cycle bit-time strobe |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle when valid |
| out_data | output | 8 | Byte to the transmitter |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Transmitter takes the output byte |
| brk_force | output | 1 | Hold the line at space level |
| cmd_err | output | 1 | One-cycle pulse for a rejected command code |

## Verification
The hardest cases to reach are the ones where the break state and the parse state interact. Examples are a data byte that waits at the input for the whole length of a break, and a literal escape pair sent in the middle of a break. The bench first opens a break with a command pair. It then offers a plain byte for several cycles and checks that the byte is refused, withdraws it, and sends the literal pair to observe the error pulse. Finally it closes the break and checks that the same byte now passes. For pause timing, a free-running tick every fourth cycle is counted from the acceptance of the length byte until `in_ready` comes back.

// File: rtl/esc_cmd_tx.sv
module esc_cmd_tx #(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] ESC     = 8'h00,
  parameter logic [DW-1:0] BRK_ON  = 8'h81,
  parameter logic [DW-1:0] PAUSE   = 8'h82,
  parameter logic [DW-1:0] BRK_OFF = 8'h83
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en,
  input  logic          tick,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          brk_force,
  output logic          cmd_err
);
  typedef enum logic [1:0] {S_DATA, S_CODE, S_LEN, S_WAIT} st_t;

  st_t           st;
  logic [DW-1:0] cnt;
  logic          slot_free, acc, is_esc;

  assign slot_free = !out_valid || out_ready;
  assign is_esc    = (in_data == ESC);
  assign acc       = in_valid && in_ready;

  always_comb begin
    case (st)
      S_DATA:  in_ready = (cmd_en && is_esc) || (slot_free && !brk_force);
      S_CODE:  in_ready = !is_esc || brk_force || slot_free;
      S_LEN:   in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_DATA;
      cnt       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      brk_force <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        S_DATA:
          if (acc) begin
            if (cmd_en && is_esc) st <= S_CODE;
            else begin
              out_valid <= 1'b1;
              out_data  <= in_data;
            end
          end
        S_CODE:
          if (acc) begin
            st <= S_DATA;
            if (is_esc) begin
              if (brk_force) cmd_err <= 1'b1;
              else begin
                out_valid <= 1'b1;
                out_data  <= in_data;
              end
            end else if (in_data == BRK_ON)  brk_force <= 1'b1;
            else if (in_data == BRK_OFF)     brk_force <= 1'b0;
            else if (in_data == PAUSE)       st <= S_LEN;
            else                             cmd_err <= 1'b1;
          end
        S_LEN:
          if (acc) begin
            if (in_data == '0) st <= S_DATA;
            else begin
              cnt <= in_data;
              st  <= S_WAIT;
            end
          end
        default:
          if (tick) begin
            cnt <= cnt - 1'b1;
            if (cnt == 1) st <= S_DATA;
          end
      endcase
    end
  end
endmodule

// File: rtl/esc_cmd_tx_chk.sv
module esc_cmd_tx_chk #(
  parameter int            DW     = 8,
  parameter logic [DW-1:0] BRK_ON = 8'h81
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_en,
  input logic          tick,
  input logic [DW-1:0] in_data,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic          brk_force,
  input logic          cmd_err
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

  AST_NO_OUT_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk_force) |-> !$rose(out_valid)); // R4

  AST_BRK_FROM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_force) |-> $past(in_valid && in_ready && in_data == BRK_ON)); // R4

  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R2
endmodule

bind esc_cmd_tx esc_cmd_tx_chk #(.DW(DW), .BRK_ON(BRK_ON)) u_chk (.*);

// File: tb/test_esc_cmd_tx.sv
module test_esc_cmd_tx;
  logic       clk = 0, rst_n = 0, cmd_en = 0, tick = 0;
  logic [7:0] in_data = 0, out_data;
  logic       in_valid = 0, in_ready, out_valid, out_ready = 1, brk_force, cmd_err;

  int nchk = 0, nerr = 0, nlog = 0, tick_cnt = 0, tphase = 0;
  logic [7:0] log_q [0:63];

  always #10 clk = ~clk;

  esc_cmd_tx i_esc_cmd_tx (.*);

  always @(negedge clk) begin
    tphase = (tphase + 1) % 4;
    tick   = rst_n && (tphase == 0);
  end
  always @(posedge clk) begin
    if (tick) tick_cnt++;
    if (rst_n && out_valid && out_ready) begin
      log_q[nlog % 64] = out_data;
      nlog++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_data = b; in_valid = 1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; in_valid = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R9 out_valid", out_valid, 0);
    chk("R9 brk_force", brk_force, 0);
    chk("R9 cmd_err", cmd_err, 0);
    chk("R9 in_ready", in_ready, 1);
  endtask

  task automatic t_disabled();
    int base = nlog;
    cmd_en = 0;
    send(8'h00); send(8'h41); send(8'h82);
    settle();
    chk("R1 count", nlog - base, 3);
    chk("R1 byte0", log_q[base % 64], 8'h00);
    chk("R1 byte1", log_q[(base+1) % 64], 8'h41);
    chk("R1 byte2", log_q[(base+2) % 64], 8'h82);
  endtask

  task automatic t_plain();
    int base = nlog;
    cmd_en = 1;
    send(8'h5A);
    chk("R2 out_valid next cycle", out_valid, 1);
    chk("R2 out_data", out_data, 8'h5A);
    send(8'hA5);
    settle();
    chk("R2 count", nlog - base, 2);
    chk("R2 second byte", log_q[(base+1) % 64], 8'hA5);
  endtask

  task automatic t_literal();
    int base;
    settle();
    base = nlog;
    send(8'h00);
    chk("R2 escape alone silent", out_valid, 0);
    send(8'h00);
    settle();
    chk("R3 count", nlog - base, 1);
    chk("R3 value", log_q[base % 64], 8'h00);
  endtask

  task automatic t_break();
    int base = nlog;
    send(8'h00); send(8'h81);
    chk("R4 brk set", brk_force, 1);
    @(negedge clk); in_data = 8'h33; in_valid = 1;
    for (int i = 0; i < 8; i++) begin
      #1; chk("R4 data refused", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0;
    chk("R4 nothing out", nlog - base, 0);
    send(8'h00); send(8'h00);
    chk("R7 literal in break err", cmd_err, 1);
    @(posedge clk); #1;
    chk("R7 err one cycle", cmd_err, 0);
    chk("R7 literal dropped", nlog - base, 0);
    send(8'h00); send(8'h83);
    chk("R5 brk clear", brk_force, 0);
    send(8'h33);
    settle();
    chk("R5 count", nlog - base, 1);
    chk("R5 byte", log_q[base % 64], 8'h33);
  endtask

  task automatic t_unknown();
    int base = nlog;
    send(8'h00); send(8'h55);
    chk("R7 err pulse", cmd_err, 1);
    @(posedge clk); #1;
    chk("R7 err drop", cmd_err, 0);
    settle();
    chk("R7 no output", nlog - base, 0);
    chk("R7 brk unaffected", brk_force, 0);
  endtask

  task automatic t_pause();
    send(8'h00); send(8'h82); send(8'h05);
    tick_cnt = 0;
    @(negedge clk); #1;
    chk("R6 stalled", in_ready, 0);
    while (!in_ready) begin @(negedge clk); #1; end
    chk("R6 tick count", tick_cnt, 5);
    send(8'h00); send(8'h82); send(8'h00);
    @(negedge clk); #1;
    chk("R6 zero length no pause", in_ready, 1);
  endtask

  task automatic t_backpressure();
    int base;
    settle();
    base = nlog;
    out_ready = 0;
    send(8'h11);
    @(negedge clk); in_data = 8'h22; in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R8 refused", in_ready, 0);
      chk("R8 data held", out_data, 8'h11);
      chk("R8 valid held", out_valid, 1);
      @(negedge clk);
    end
    out_ready = 1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; in_valid = 0;
    settle();
    chk("R8 count", nlog - base, 2);
    chk("R8 order", log_q[(base+1) % 64], 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_plain();
    t_literal();
    t_break();
    t_unknown();
    t_pause();
    t_backpressure();
    settle();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule